// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

The block manages up to six banks of 32 general-purpose pins. For every bank it holds a direction latch, an output latch, rising and falling edge enables and a sticky edge-status word. Pad inputs are synchronised through two flops before anything reads them. Output levels change only through strobes: writing a mask to the set register raises the masked pins, and writing a mask to the clear register lowers them. Status bits are cleared by writing ones to them, and one interrupt line is high while any status bit is set.

Software reaches the banks over a plain word-addressed register bus with address, write enable, write data and combinational read data. Every access completes in one cycle, so the bus has no handshake. The pads appear as three flat vectors: input, output and output enable. When the pin count is not a multiple of 32, the last bank is narrower than the others.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq` is low.
- R2: The word address of a register is `(bank >= 3 ? 0x40 : 0) + kind*3 + (bank mod 3)`. The kind codes are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable and 6 status. Word addresses with a low six-bit value of 21 or more decode to nothing.
- R3: A write to the set register ORs the data into the bank's output latch, and `pad_out` shows the latch one cycle later. Reads of the set or clear register return the latch.
- R4: A write to the clear register drives to 0 each latch bit whose data bit is 1. Latch bits whose data bit is 0 keep their value.
- R5: A direction bit of 1 makes the pin an output, and `pad_oe` follows the direction register one cycle after the write.
- R6: The level register returns `pad_in` through a two-flop synchroniser, whatever the pin's direction. A change on `pad_in` is readable after two clock edges.
- R7: A rising edge on a pin whose rising enable is set latches its status bit on the third clock edge after the pad changes. If the enable is clear, the edge has no effect.
- R8: A falling edge on a pin whose falling enable is set latches its status bit. If the enable is clear, the edge has no effect.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Without a write, a set status bit stays set.
- R10: If an edge event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R11: In a partial last bank, bits above the implemented width read as zero and ignore writes.
- R12: `irq` is high exactly when at least one status bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Word address |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Output latch |
| pad_oe | output | NUM_PINS | Output enable (direction) |
| irq | output | 1 | High while any status bit is set |

## Verification
Register writes take effect at the clock edge that samples the strobe. Reads are combinational, so the bench drives the strobe at a falling edge and reads back one falling edge later. A pad change reaches the level register after two rising edges and the status register after three. The bench therefore changes pads at a falling edge and samples level after three falling edges and status after four. The collision case needs a clearing write exactly on the third rising edge after the pad change, so the bench counts falling edges to place the write strobe on that edge.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int BANK_W      = 32;
  localparam int GROUP_BANKS = 3;
  localparam int ADDR_W      = 7;
  localparam int KIND_SLOTS  = 7;

  typedef enum logic [2:0] {
    K_LEVEL = 3'd0,
    K_DIR   = 3'd1,
    K_SET   = 3'd2,
    K_CLR   = 3'd3,
    K_RISE  = 3'd4,
    K_FALL  = 3'd5,
    K_STAT  = 3'd6,
    K_NONE  = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic [BANK_W-1:0] level;
    logic [BANK_W-1:0] dir;
    logic [BANK_W-1:0] outl;
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] fall;
    logic [BANK_W-1:0] stat;
  } bank_view_t;

  // R2: kind = slot / 3 within a window
  function automatic reg_kind_e kind_of(input logic [ADDR_W-1:0] a);
    logic [5:0] w;
    w = a[5:0];
    if (w >= 6'(KIND_SLOTS * GROUP_BANKS)) return K_NONE;
    return reg_kind_e'(3'(w / 6'(GROUP_BANKS)));
  endfunction

  // R2: bank = window*3 + slot mod 3
  function automatic logic [2:0] bank_of(input logic [ADDR_W-1:0] a);
    logic [5:0] w;
    w = a[5:0];
    return (a[6] ? 3'(GROUP_BANKS) : 3'd0) + 3'(w % 6'(GROUP_BANKS));
  endfunction
endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise_ev,
  output logic [W-1:0] fall_ev
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level   = sync_q;
  assign rise_ev = sync_q & ~prev_q;
  assign fall_ev = ~sync_q & prev_q;
endmodule

// File: rtl/pbc_bank.sv
module pbc_bank
  import pbc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output bank_view_t   view,
  output logic         any_stat
);
  logic [W-1:0] level, rise_ev, fall_ev;
  logic [W-1:0] dir_q, out_q, rise_q, fall_q, stat_q;
  logic [W-1:0] clr_mask, stat_nxt;

  pbc_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  always_comb begin
    clr_mask = (sel && kind == K_STAT) ? wdata : '0;
    // R10: new events are ORed after the clear so they survive it
    stat_nxt = (stat_q & ~clr_mask) | (rise_ev & rise_q) | (fall_ev & fall_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (sel) begin
        unique case (kind)
          K_DIR:   dir_q  <= wdata;
          K_SET:   out_q  <= out_q | wdata;
          K_CLR:   out_q  <= out_q & ~wdata;
          K_RISE:  rise_q <= wdata;
          K_FALL:  fall_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign pad_out  = out_q;
  assign pad_oe   = dir_q;
  assign any_stat = |stat_q;

  always_comb begin
    view       = '0;
    view.level = BANK_W'(level);
    view.dir   = BANK_W'(dir_q);
    view.outl  = BANK_W'(out_q);
    view.rise  = BANK_W'(rise_q);
    view.fall  = BANK_W'(fall_q);
    view.stat  = BANK_W'(stat_q);
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pbc_pkg::*;
#(
  parameter int NUM_PINS = 112
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int NBANK = (NUM_PINS + BANK_W - 1) / BANK_W;

  reg_kind_e   dec_kind;
  logic [2:0]  dec_bank;
  bank_view_t  views [NBANK];
  logic [NBANK-1:0] stat_any;

  assign dec_kind = kind_of(bus_addr);
  assign dec_bank = bank_of(bus_addr);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int W = (NUM_PINS - b*BANK_W >= BANK_W) ? BANK_W : NUM_PINS - b*BANK_W;
    logic sel;
    assign sel = bus_we && (dec_kind != K_NONE) && (dec_bank == 3'(b));

    pbc_bank #(.W(W)) u_bank (
      .clk(clk), .rst(rst), .sel(sel), .kind(dec_kind),
      .wdata(bus_wdata[W-1:0]),
      .pad_in(pad_in[b*BANK_W +: W]),
      .pad_out(pad_out[b*BANK_W +: W]),
      .pad_oe(pad_oe[b*BANK_W +: W]),
      .view(views[b]), .any_stat(stat_any[b])
    );
  end

  assign irq = |stat_any;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (dec_bank == 3'(b)) begin
        unique case (dec_kind)
          K_LEVEL:      bus_rdata = views[b].level;
          K_DIR:        bus_rdata = views[b].dir;
          K_SET, K_CLR: bus_rdata = views[b].outl;
          K_RISE:       bus_rdata = views[b].rise;
          K_FALL:       bus_rdata = views[b].fall;
          K_STAT:       bus_rdata = views[b].stat;
          default:      bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int NUM_PINS = 112
) (
  input logic                clk,
  input logic                rst,
  input logic [6:0]          bus_addr,
  input logic                bus_we,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d) begin
      AST_RST_IDLE: assert (!irq && pad_oe == '0 && pad_out == '0); // R1
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 7'd6) |=> ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 7'd9) |=> ((pad_out[31:0] & $past(bus_wdata)) == 32'd0)); // R4

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 7'd3) |=> (pad_oe[31:0] == $past(bus_wdata))); // R5

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && !bus_we) |=> irq); // R9
endmodule

bind pin_bank_ctrl pbc_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/pin_bank_ctrl_test.sv
module pin_bank_ctrl_test;
  localparam int NP = 112;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [6:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pin_bank_ctrl #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // R2 address formula
  function automatic logic [6:0] wa(input int kind, input int bank);
    return 7'((bank >= 3 ? 64 : 0) + kind * 3 + bank % 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int bank, input logic [31:0] d);
    @(negedge clk);
    bus_addr = wa(kind, bank); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int kind, input int bank, output logic [31:0] d);
    bus_addr = wa(kind, bank);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {kind[2:0], bank[2:0], wdata, expected readback}
  localparam logic [69:0] VEC [8] = '{
    {3'd1, 3'd0, 32'hA5A5A5A5, 32'hA5A5A5A5},  // R5 direction
    {3'd4, 3'd1, 32'h0000FFFF, 32'h0000FFFF},  // R2 rise enable bank1
    {3'd5, 3'd2, 32'h12345678, 32'h12345678},  // R2 fall enable bank2
    {3'd1, 3'd3, 32'hFFFFFFFF, 32'h0000FFFF},  // R11 partial bank, second window
    {3'd2, 3'd0, 32'hF0F0F0F0, 32'hF0F0F0F0},  // R3 set
    {3'd3, 3'd0, 32'h30303030, 32'hC0C0C0C0},  // R4 clear
    {3'd2, 3'd3, 32'hFFFFFFFF, 32'h0000FFFF},  // R11 set partial bank
    {3'd4, 3'd3, 32'hFFFF0000, 32'h00000000}   // R11 ignored upper bits
  };

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 7; k++) begin
      rd(k, 1, r); check("R1 reg zero", r, 32'd0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pad_oe", pad_oe[31:0], 32'd0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      wr(int'(VEC[i][69:67]), int'(VEC[i][66:64]), VEC[i][63:32]);
      rd(int'(VEC[i][69:67]), int'(VEC[i][66:64]), r);
      check("R2 table readback", r, VEC[i][31:0]);
    end
    check("R3 R4 pad_out", pad_out[31:0], 32'hC0C0C0C0);
    check("R5 pad_oe", pad_oe[31:0], 32'hA5A5A5A5);
    check("R11 pad_oe bank3", {16'd0, pad_oe[111:96]}, 32'h0000FFFF);

    // R6 level through synchroniser
    @(negedge clk);
    pad_in[31:0] = 32'hDEADBEEF;
    pad_in[111:96] = 16'hFFFF;
    @(negedge clk);
    rd(0, 0, r); check("R6 level not yet", r, 32'd0);
    wait_n(2);
    rd(0, 0, r); check("R6 level", r, 32'hDEADBEEF);
    rd(0, 3, r); check("R11 level bank3", r, 32'h0000FFFF);
    wait_n(2);
    check("R12 no edges enabled irq", {31'd0, irq}, 32'd0);

    // R7 rising edge on pin 32 (bank1 bit0)
    pad_in[32] = 1'b1;
    wait_n(4);
    rd(6, 1, r); check("R7 rising latched", r, 32'd1);
    check("R12 irq high", {31'd0, irq}, 32'd1);
    // R8 falling edge, falling enable clear on bank1
    pad_in[32] = 1'b0;
    wait_n(4);
    rd(6, 1, r); check("R8 disabled fall keeps", r, 32'd1);
    // R9 writing zero keeps
    wr(6, 1, 32'd0);
    rd(6, 1, r); check("R9 write zero", r, 32'd1);

    // R10 collision: edge lands on the same edge as a clearing write
    pad_in[32] = 1'b1;      // at negedge N0
    wait_n(2);              // now at N2, edge pending
    bus_addr = wa(6, 1); bus_wdata = 32'd1; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(6, 1, r); check("R10 collision stays set", r, 32'd1);

    // R9 plain clear
    wr(6, 1, 32'hFFFFFFFF);
    rd(6, 1, r); check("R9 clear", r, 32'd0);
    check("R12 irq low", {31'd0, irq}, 32'd0);

    // R7 negative / R8 positive on pin 67 (bank2 bit3)
    pad_in[67] = 1'b1;
    wait_n(4);
    rd(6, 2, r); check("R7 disabled rise ignored", r, 32'd0);
    pad_in[67] = 1'b0;
    wait_n(4);
    rd(6, 2, r); check("R8 falling latched", r, 32'h00000008);
    check("R12 irq from bank2", {31'd0, irq}, 32'd1);
    wr(6, 2, 32'h00000008);
    rd(6, 2, r); check("R9 single clear", r, 32'd0);

    // R2 out-of-range slot decodes to nothing
    @(negedge clk);
    bus_addr = 7'd21; #1;
    check("R2 unmapped read", bus_rdata, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule